// File: doc/BRIEF.md
# Multi-format serial frame transmitter

This block turns one byte from a host into a serial bit stream, using one of five frame formats picked by a 3-bit format code. One format is a plain synchronous shift of eight data bits, with a gated clock strobe for the receiver. The other four are asynchronous frames. Each has a low start bit and a high stop bit. Between them sit the data bits and, depending on the format, an even-parity bit, an odd-parity bit or an address/data type bit for multidrop links. A separate control input sets whether the data bits go out least significant bit first or most significant bit first.

The host presents a byte on `load_data` together with a one-cycle `load` strobe. The block accepts it only when it is idle and the format code is valid. At that point it captures the complete frame, so later changes to the inputs do not alter the frame in flight. An external bit-rate enable (`bit_tick`) advances the frame one bit per tick. When the last bit ends, `busy` falls and `done` pulses for one cycle.

Top module: `serial_frame_tx`

## Requirements
- R1: During and after reset, `ser_out` is 1, and `busy`, `done` and `sclk_out` are 0.
- R2: Format code 000 sends exactly 8 data bits, with no start bit and no stop bit. `sclk_out` is high exactly in the cycles where `bit_tick` is high during such a frame, and `ser_out` holds the current bit across that strobe.
- R3: Format code 010 sends 10 bits in this order: a start bit of 0, 8 data bits, then a stop bit of 1. Outside a frame, `ser_out` idles at 1.
- R4: Format code 100 sends 11 bits: start 0, 8 data bits, a parity bit that makes the number of ones across the data and parity bits even, then stop 1.
- R5: Format code 101 sends the same 11-bit layout as code 100, except that the parity bit makes that count of ones odd.
- R6: Format code 110 sends 11 bits: start 0, 8 data bits, a type bit equal to `addr_flag` at load time (1 means address, 0 means data), then stop 1.
- R7: Codes 001, 011 and 111 are reserved. A `load` under any of them starts no frame: `busy` stays 0 and `ser_out` stays 1.
- R8: With `msb_first`=0 the data bits go out bit 0 first. With `msb_first`=1 they go out bit 7 first. The parity or type bit always follows the eighth data bit, and the stop bit comes after it.
- R9: Each bit stays on `ser_out` until the next `bit_tick`, which advances the frame by one bit. While `busy` is 1, a `load` is ignored, and so are changes to `load_data`, `word_sel`, `msb_first` and `addr_flag`. None of these alter the frame in flight.
- R10: The frame starts in the cycle after an accepted `load`. In the cycle after the tick that ends the last bit, `busy` is 0 and `done` is 1 for exactly one cycle. A new `load` is accepted from that cycle on.
- R11: `sclk_out` stays 0 throughout the asynchronous formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-rate enable; one tick ends one bit |
| word_sel | input | 3 | Frame format code |
| msb_first | input | 1 | Data bit order: 0 sends bit 0 first, 1 sends bit 7 first |
| load | input | 1 | Strobe that offers `load_data` for sending |
| load_data | input | DATA_W | Byte to send |
| addr_flag | input | 1 | Type bit for multidrop frames (1 = address) |
| ser_out | output | 1 | Serial data line |
| sclk_out | output | 1 | Gated bit strobe in synchronous format |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench builds the block with the default `DATA_W` of 8, which is small enough to sweep exhaustively. It sends every one of the 256 byte values in every valid format and in both bit orders, and for multidrop frames with both values of the type flag. This covers every parity outcome and every bit position in every order. In half of those frames a conflicting load, with a different format, order and data, is driven mid-frame. The reserved codes are each tried with ticks running, to show that the line never leaves idle.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [2:0]        word_sel,
  input  logic              msb_first,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              addr_flag,
  output logic              ser_out,
  output logic              sclk_out,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [2:0] WS_SYNC  = 3'b000;
  localparam logic [2:0] WS_PLAIN = 3'b010;
  localparam logic [2:0] WS_EVEN  = 3'b100;
  localparam logic [2:0] WS_ODD   = 3'b101;
  localparam logic [2:0] WS_MDROP = 3'b110;

  logic [DATA_W-1:0]  ordered;
  logic [FRAME_W-1:0] frame_new, shreg;
  logic [CNT_W-1:0]   len_new, remain;
  logic               fmt_ok, sync_q, accept;

  always_comb
    for (int i = 0; i < DATA_W; i++)
      ordered[i] = msb_first ? load_data[DATA_W-1-i] : load_data[i];

  always_comb begin
    fmt_ok    = 1'b1;
    frame_new = '1;
    len_new   = CNT_W'(FRAME_W);
    case (word_sel)
      WS_SYNC: begin
        frame_new = {3'b111, ordered};
        len_new   = CNT_W'(DATA_W);
      end
      WS_PLAIN: begin
        frame_new = {2'b11, ordered, 1'b0};
        len_new   = CNT_W'(DATA_W + 2);
      end
      WS_EVEN:  frame_new = {1'b1, ^load_data, ordered, 1'b0};
      WS_ODD:   frame_new = {1'b1, ~^load_data, ordered, 1'b0};
      WS_MDROP: frame_new = {1'b1, addr_flag, ordered, 1'b0};
      default: begin
        fmt_ok  = 1'b0;
        len_new = '0;
      end
    endcase
  end

  assign accept = load & ~busy & fmt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        shreg  <= frame_new;
        remain <= len_new;
        busy   <= 1'b1;
        sync_q <= (word_sel == WS_SYNC);
      end else if (busy && bit_tick) begin
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign ser_out  = busy ? shreg[0] : 1'b1;
  assign sclk_out = busy & sync_q & bit_tick;
endmodule

// File: rtl/serial_frame_tx_checks.sv
module serial_frame_tx_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic [2:0] word_sel,
  input logic       load,
  input logic       ser_out,
  input logic       sclk_out,
  input logic       busy,
  input logic       done
);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(word_sel) != 3'b000) |-> !ser_out);

  p_reserved_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && (word_sel == 3'b001 || word_sel == 3'b011 || word_sel == 3'b111))
      |=> !busy);

  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(ser_out));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_sclk_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out |-> (busy && bit_tick));
endmodule

bind serial_frame_tx serial_frame_tx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_sel(word_sel),
  .load(load), .ser_out(ser_out), .sclk_out(sclk_out), .busy(busy), .done(done)
);

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n, bit_tick, msb_first, load, addr_flag;
  logic [2:0] word_sel;
  logic [7:0] load_data;
  logic       ser_out, sclk_out, busy, done;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  serial_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_sel(word_sel),
    .msb_first(msb_first), .load(load), .load_data(load_data),
    .addr_flag(addr_flag), .ser_out(ser_out), .sclk_out(sclk_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int frame_len(input logic [2:0] ws);
    if (ws == 3'b000) return 8;
    if (ws == 3'b010) return 10;
    return 11;
  endfunction

  function automatic logic exp_bit(input logic [2:0] ws, input logic msb,
                                   input logic [7:0] d, input logic af, input int idx);
    int ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(d[k]);
    if (ws == 3'b000) return msb ? d[7-idx] : d[idx];
    if (idx == 0) return 1'b0;
    if (idx <= 8) return msb ? d[8-idx] : d[idx-1];
    if (ws == 3'b010 || idx == 10) return 1'b1;
    case (ws)
      3'b100:  return (ones % 2) == 1;
      3'b101:  return (ones % 2) == 0;
      default: return af;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] ws, input logic msb);
    string t;
    case (ws)
      3'b000:  t = "R2";
      3'b010:  t = "R3";
      3'b100:  t = "R4";
      3'b101:  t = "R5";
      default: t = "R6";
    endcase
    if (msb) t = {t, "/R8"};
    return t;
  endfunction

  task automatic send(input logic [2:0] ws, input logic msb, input logic [7:0] d,
                      input logic af, input bit inject);
    int    len = frame_len(ws);
    string t = tag(ws, msb);
    word_sel = ws; msb_first = msb; load_data = d; addr_flag = af; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R10 busy after load", busy, 1);
    for (int i = 0; i < len; i++) begin
      chk({t, " bit"}, ser_out, exp_bit(ws, msb, d, af, i));
      chk({t, " sclk low without tick"}, sclk_out, 0);
      bit_tick = 1'b1;
      #1;
      chk(ws == 3'b000 ? "R2 sclk strobe" : "R11 sclk quiet", sclk_out, ws == 3'b000);
      chk({t, " bit held at tick"}, ser_out, exp_bit(ws, msb, d, af, i));
      @(negedge clk);
      bit_tick = 1'b0;
      if (i == len - 1) break;
      if (inject && i == 2) begin
        load = 1'b1; load_data = ~d; word_sel = 3'b000; msb_first = ~msb; addr_flag = ~af;
      end
      @(negedge clk);
      load = 1'b0;
      chk("R9 load ignored while busy", busy, 1);
    end
    chk("R10 done pulse", done, 1);
    chk("R10 busy falls", busy, 0);
    chk("R3 idle high after frame", ser_out, 1);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes [5] = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110};
    logic [2:0] rsv [3]   = '{3'b001, 3'b011, 3'b111};
    rst_n = 1'b0; bit_tick = 1'b0; msb_first = 1'b0; load = 1'b0;
    addr_flag = 1'b0; word_sel = 3'b000; load_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset ser_out", ser_out, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset sclk", sclk_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", ser_out, 1);

    foreach (rsv[r]) begin
      word_sel = rsv[r]; load_data = 8'h00; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk("R7 reserved no busy", busy, 0);
      chk("R7 reserved line idle", ser_out, 1);
      for (int k = 0; k < 4; k++) begin
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        chk("R7 reserved stays idle", ser_out, 1);
        chk("R7 reserved no done", done, 0);
      end
    end

    foreach (modes[m])
      for (int msb = 0; msb < 2; msb++)
        for (int d = 0; d < 256; d++)
          for (int af = 0; af < ((modes[m] == 3'b110) ? 2 : 1); af++)
            send(modes[m], 1'(msb), 8'(d), 1'(af), d[0]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule